// File: doc/BRIEF.md
# Decoded I/O Output Port Bank

This block sits on a processor-style bus and turns I/O write cycles into eight byte-wide latched output ports, 64 output lines in all. Each bus cycle is qualified as an I/O access from the memory/IO select line. Only then is the port address examined: a fixed high-order enable bit must be set, the lowest bit must be clear, and three address bits pick one of the eight ports. The byte on the data bus is stored in the selected port and stays there until software writes to that same port again.

The write strobe and reset come from the bus side and are treated as asynchronous. The strobe is brought into the system clock domain through a synchroniser. While the strobe is low, the address, data and select lines are sampled. The port is loaded on the synchronised rising edge of the strobe. Reset is applied asynchronously and released in step with the clock. A processor drives the block with ordinary output instructions to even port numbers that have the enable bit set. For example, port number 0x8000 reaches port 0 and 0x8002 reaches port 1.

Top module: `ioport_out_bank`

## Requirements
- R1: While reset is applied, and after it is released, all 64 output lines read 0x00 until the first accepted write.
- R2: An accepted write stores the data byte into port k = address bits [3:1], which drives port_out[8k+7:8k]. Address 0x08000 reaches port 0 and address 0x08002 reaches port 1.
- R3: A write with mem_io_n = 1 (a memory cycle) changes no output line.
- R4: A write to an odd address (bit 0 = 1) changes no output line.
- R5: A write whose address bit 15 is 0 changes no output line.
- R6: A write with any of address bits [19:16] non-zero changes no output line.
- R7: An accepted write changes only the selected port. The other seven ports keep their values, and a port keeps its value until the next accepted write to it.
- R8: The port is loaded only after the strobe wr_n returns high. While wr_n is held low the outputs do not change. The new value appears no later than four clock cycles after wr_n rises.
- R9: Activity on mem_io_n, addr and data while wr_n stays high, which includes I/O reads, changes no output line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mem_io_n | input | 1 | Cycle type: 1 = memory, 0 = I/O |
| wr_n | input | 1 | Active-low write strobe, asynchronous to clk |
| addr | input | 20 | Bus address; the I/O port number occupies bits [15:0] |
| data | input | 8 | Write data byte |
| port_out | output | 64 | Eight latched ports; port k occupies bits [8k+7:8k] |

## Verification
All eight ports are written at their even addresses with distinct data bytes, so a wrong index mapping or a byte lane error shows up as a mismatched image. Port 0 and port 1 are then rewritten to confirm that the other ports hold their values. Writes are then rejected one qualifier at a time: a memory cycle, an odd address, bit 15 clear, and a non-zero upper nibble. Each rejected write carries a data byte that would be visible if that qualifier were dropped. A long low strobe is sampled both mid-pulse and after release, which tells loading on the trailing edge apart from loading on the leading edge. Bus activity with the strobe high, and a read-like I/O cycle, confirm that nothing changes without a write.

// File: rtl/ioport_pkg.sv
package ioport_pkg;
  localparam int unsigned DEF_NUM_PORTS  = 8;
  localparam int unsigned DEF_PORT_W     = 8;
  localparam int unsigned DEF_ADDR_W     = 20;
  localparam int unsigned DEF_IO_SPACE_W = 16;
  localparam int unsigned DEF_SEL_LSB    = 1;
  localparam int unsigned DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/ioport_strobe_sync.sv
module ioport_strobe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  input  logic wr_n_async,
  output logic rst_n_sync,
  output logic wr_low,
  output logic wr_rise
);
  logic [STAGES-1:0] rst_q, rst_d;
  logic [STAGES:0]   wr_q, wr_d;

  always_comb begin
    rst_d = {rst_q[STAGES-2:0], 1'b1};
    wr_d  = {wr_q[STAGES-1:0], wr_n_async};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) rst_q <= '0;
    else              rst_q <= rst_d;
  end

  assign rst_n_sync = rst_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) wr_q <= '1;
    else             wr_q <= wr_d;
  end

  assign wr_low  = ~wr_q[STAGES-1];
  assign wr_rise = wr_q[STAGES-1] & ~wr_q[STAGES];
endmodule

// File: rtl/ioport_addr_decode.sv
module ioport_addr_decode #(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned IO_SPACE_W = 16,
  parameter int unsigned SEL_LSB    = 1,
  parameter int unsigned NUM_PORTS  = 8,
  localparam int unsigned IDX_W     = $clog2(NUM_PORTS),
  localparam int unsigned EN_BIT    = IO_SPACE_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_low,
  input  logic              wr_rise,
  input  logic              mem_io_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              cap_mem_io_n,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [DATA_W-1:0] cap_data,
  output logic              wr_fire,
  output logic [IDX_W-1:0]  wr_idx
);
  logic              mem_d;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] data_d;
  logic              io_hit;

  always_comb begin
    mem_d  = cap_mem_io_n;
    addr_d = cap_addr;
    data_d = cap_data;
    if (wr_low) begin
      mem_d  = mem_io_n;
      addr_d = addr;
      data_d = data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_mem_io_n <= 1'b1;
      cap_addr     <= '0;
      cap_data     <= '0;
    end else begin
      cap_mem_io_n <= mem_d;
      cap_addr     <= addr_d;
      cap_data     <= data_d;
    end
  end

  always_comb begin
    io_hit = ~cap_mem_io_n
           & ~(|cap_addr[ADDR_W-1:IO_SPACE_W])
           & cap_addr[EN_BIT]
           & ~cap_addr[0];
    wr_fire = wr_rise & io_hit;
    wr_idx  = cap_addr[SEL_LSB +: IDX_W];
  end
endmodule

// File: rtl/ioport_latch_bank.sv
module ioport_latch_bank #(
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned PORT_W    = 8,
  localparam int unsigned IDX_W    = $clog2(NUM_PORTS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_fire,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [PORT_W-1:0]           wr_data,
  output logic [NUM_PORTS*PORT_W-1:0] ports
);
  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    logic              en;
    logic [PORT_W-1:0] q, d;

    always_comb begin
      en = wr_fire && (wr_idx == IDX_W'(i));
      d  = en ? wr_data : q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end

    assign ports[i*PORT_W +: PORT_W] = q;
  end
endmodule

// File: rtl/ioport_out_bank.sv
module ioport_out_bank
  import ioport_pkg::*;
#(
  parameter int unsigned NUM_PORTS   = DEF_NUM_PORTS,
  parameter int unsigned PORT_W      = DEF_PORT_W,
  parameter int unsigned ADDR_W      = DEF_ADDR_W,
  parameter int unsigned IO_SPACE_W  = DEF_IO_SPACE_W,
  parameter int unsigned SEL_LSB     = DEF_SEL_LSB,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
  localparam int unsigned IDX_W      = $clog2(NUM_PORTS),
  localparam int unsigned OUT_W      = NUM_PORTS * PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_io_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PORT_W-1:0] data,
  output logic [OUT_W-1:0]  port_out
);
  logic              rst_n_s;
  logic              wr_low;
  logic              wr_rise;
  logic              cap_mem_io_n;
  logic [ADDR_W-1:0] cap_addr;
  logic [PORT_W-1:0] cap_data;
  logic              wr_fire;
  logic [IDX_W-1:0]  wr_idx;

  ioport_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n_async(rst_n), .wr_n_async(wr_n),
    .rst_n_sync(rst_n_s), .wr_low(wr_low), .wr_rise(wr_rise)
  );

  ioport_addr_decode #(
    .ADDR_W(ADDR_W), .DATA_W(PORT_W), .IO_SPACE_W(IO_SPACE_W),
    .SEL_LSB(SEL_LSB), .NUM_PORTS(NUM_PORTS)
  ) u_dec (
    .clk(clk), .rst_n(rst_n_s), .wr_low(wr_low), .wr_rise(wr_rise),
    .mem_io_n(mem_io_n), .addr(addr), .data(data),
    .cap_mem_io_n(cap_mem_io_n), .cap_addr(cap_addr), .cap_data(cap_data),
    .wr_fire(wr_fire), .wr_idx(wr_idx)
  );

  ioport_latch_bank #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_bank (
    .clk(clk), .rst_n(rst_n_s), .wr_fire(wr_fire), .wr_idx(wr_idx),
    .wr_data(cap_data), .ports(port_out)
  );
endmodule

// File: rtl/ioport_out_bank_chk.sv
module ioport_out_bank_chk #(
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned PORT_W    = 8,
  parameter int unsigned ADDR_W    = 20,
  localparam int unsigned IDX_W    = $clog2(NUM_PORTS),
  localparam int unsigned OUT_W    = NUM_PORTS * PORT_W
) (
  input logic              clk,
  input logic              rst_n_s,
  input logic              wr_rise,
  input logic              wr_fire,
  input logic [IDX_W-1:0]  wr_idx,
  input logic              cap_mem_io_n,
  input logic [ADDR_W-1:0] cap_addr,
  input logic [PORT_W-1:0] cap_data,
  input logic [OUT_W-1:0]  port_out
);
  logic [OUT_W-1:0]     prev_out;
  logic [NUM_PORTS-1:0] byte_diff;
  logic [PORT_W-1:0]    sel_byte;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) prev_out <= '0;
    else          prev_out <= port_out;
  end

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_diff
    assign byte_diff[i] = |(prev_out[i*PORT_W +: PORT_W] ^ port_out[i*PORT_W +: PORT_W]);
  end

  always_comb sel_byte = port_out[wr_idx*PORT_W +: PORT_W];

  // R1: outputs are clear while the internal reset is held
  always @(negedge clk) begin
    if (!rst_n_s) p_reset_clear_r1: assert (port_out == '0);
  end

  // R2: an accepted write lands in the selected byte lane
  p_data_lands_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    wr_fire |=> (port_out[$past(wr_idx)*PORT_W +: PORT_W] == $past(cap_data)));

  // R3: memory cycles leave the outputs alone
  p_mem_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_rise && cap_mem_io_n) |=> $stable(port_out));

  // R4: odd addresses leave the outputs alone
  p_odd_addr_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_rise && cap_addr[0]) |=> $stable(port_out));

  // R7: at most one port changes per cycle
  p_one_port_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0(byte_diff));

  // R8: without a strobe release the outputs hold
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    !wr_rise |=> $stable(port_out));
endmodule

bind ioport_out_bank ioport_out_bank_chk #(
  .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n_s(rst_n_s), .wr_rise(wr_rise), .wr_fire(wr_fire),
  .wr_idx(wr_idx), .cap_mem_io_n(cap_mem_io_n), .cap_addr(cap_addr),
  .cap_data(cap_data), .port_out(port_out)
);

// File: tb/test_ioport_out_bank.sv
`timescale 1ns/100ps
module test_ioport_out_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mem_io_n;
  logic        wr_n;
  logic [19:0] addr;
  logic [7:0]  data;
  logic [63:0] port_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [7:0]  model [8];
  logic [63:0] exp_q [$];
  string       tag_q [$];

  always #2.5 clk = ~clk;

  ioport_out_bank i_ioport_out_bank (
    .clk(clk), .rst_n(rst_n), .mem_io_n(mem_io_n), .wr_n(wr_n),
    .addr(addr), .data(data), .port_out(port_out)
  );

  function automatic logic [63:0] image();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = model[i];
    return v;
  endfunction

  task automatic expect_now(string tag);
    exp_q.push_back(image());
    tag_q.push_back(tag);
    @(negedge clk);
    @(negedge clk);
  endtask

  // Driver: one bus write, updates the reference model from the requirements.
  task automatic bus_write(logic mio, logic [19:0] a, logic [7:0] d,
                           int low_cycles, string tag);
    @(negedge clk);
    mem_io_n = mio; addr = a; data = d;
    @(negedge clk);
    wr_n = 1'b0;
    repeat (low_cycles) @(negedge clk);
    if (low_cycles > 6) expect_now({tag, " mid-strobe"});
    wr_n = 1'b1;
    repeat (6) @(negedge clk);
    if (!mio && a[19:16] == 4'h0 && a[15] && !a[0]) model[a[3:1]] = d;
    expect_now(tag);
  endtask

  // Monitor: pops expected images and compares them with the outputs.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (port_out !== e) begin
          failures++;
          $display("FAIL %s: port_out=%h expected=%h", t, port_out, e);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    rst_n = 1'b0; mem_io_n = 1'b1; wr_n = 1'b1; addr = '0; data = '0;
    repeat (3) @(negedge clk);
    expect_now("R1 during reset");
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    expect_now("R1 after reset");

    bus_write(1'b0, 20'h08000, 8'hA5, 2, "R2 port0 at 0x8000");
    bus_write(1'b0, 20'h08002, 8'h3C, 2, "R2 port1 at 0x8002");
    for (int p = 2; p < 8; p++)
      bus_write(1'b0, 20'h08000 | 20'(p*2), 8'(8'h10 + p*8'h11), 3, "R2 port k from A3..A1");
    bus_write(1'b0, 20'h08FF0, 8'h77, 2, "R2 high port bits ignored for index");
    bus_write(1'b0, 20'h08002, 8'hC3, 2, "R7 rewrite port1 others hold");

    bus_write(1'b1, 20'h08004, 8'hEE, 2, "R3 memory cycle ignored");
    bus_write(1'b0, 20'h08007, 8'hDD, 2, "R4 odd address ignored");
    bus_write(1'b0, 20'h00006, 8'hCC, 2, "R5 bit15 clear ignored");
    bus_write(1'b0, 20'h18008, 8'hBB, 2, "R6 upper nibble ignored");
    bus_write(1'b0, 20'h8800A, 8'hAA, 2, "R6 bit19 ignored");

    bus_write(1'b0, 20'h0800C, 8'h5A, 10, "R8 long strobe loads on release");

    // R9: bus activity with the strobe high
    @(negedge clk);
    mem_io_n = 1'b0; addr = 20'h0800E; data = 8'h99;
    repeat (4) @(negedge clk);
    mem_io_n = 1'b1; addr = 20'h08000; data = 8'h00;
    repeat (4) @(negedge clk);
    expect_now("R9 strobe high changes nothing");

    bus_write(1'b0, 20'h08000, 8'h01, 1, "R7 port0 again short strobe");
    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule